// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Decoder

This block sits on the command side of a two-bank synchronous graphics DRAM model. On every rising clock edge it samples the chip select, the three strobe pins, a special-function input and the address bus. It names the command it sees, including the graphics forms that appear when the special-function input is high: a masked activate, a block write and a load of the special mode register. It also decides whether the command is legal in the present state of the banks. Each bank is tracked as idle, active or precharging. The block keeps the normal and special mode registers and follows burst progress, so that bursts that end in an automatic precharge close their bank without a further command.

The classification, the legality flag and the bank state all appear one clock after the edge that sampled the command. A rejected command changes no bank state and no register. Bank state still advances on its own through burst countdown and precharge timing. The block has no storage array and does not model analog timing or a data path.

Top module: `sgdram_cmd_decoder`

## Requirements
- R1: Pins are decoded as {cs_n, ras_n, cas_n, we_n}. When cs_n is 1, or the pins are 0111, the code is idle (0). Otherwise: 0000 gives mode load (1), or special mode load (2) when dsf=1. 0011 gives activate (3), or masked activate (4) when dsf=1. 0010 gives precharge (5), or precharge-all (6) when addr[9]=1. 0101 gives read (7). 0100 gives write (8), or block write (9) when dsf=1. 0110 gives burst stop (10). 0001 gives auto refresh (11). The code appears on cmd_o one clock after the sampling edge.
- R2: addr[10] selects the bank for activate, read, write and single precharge (0 selects bank 0, 1 selects bank 1). An activate opens an idle bank. An activate to a bank that is not idle is illegal.
- R3: A precharge with addr[9]=1 acts on both banks and ignores addr[10]. An active bank that is precharged reports neither idle nor active for TRP clocks (default 2) and then reports idle. An activate sampled before that point is illegal.
- R4: A read or write to a bank that is not active is illegal and leaves the state of both banks unchanged.
- R5: Auto refresh, mode load and special mode load are legal only when both banks are idle.
- R6: The dsf value sampled with an accepted activate sets that bank's wpb_o bit. The bit holds until the bank is precharged, and then it clears.
- R7: A write with dsf=1 is reported as a block write. It is legal under the same rules as a normal write.
- R8: An accepted mode load copies addr into mr_o. An accepted special mode load copies addr into smr_o and leaves mr_o alone. A rejected load changes neither register.
- R9: A read or write with addr[8]=1 runs its burst and then precharges its bank without a further command, for TRP clocks, before the bank goes idle. From the accepted command until that bank reports idle, every read or write to either bank is illegal, and so is any precharge that covers that bank.
- R10: The burst length comes from mr_o[2:0]: codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and all higher codes give 8 beats. When mr_o[9]=1, writes last one beat. burst_o[b] is high for as many clocks as the burst has beats, starting with the clock after the command.
- R11: A burst stop is legal in every state and for every burst length. It ends any burst that has no auto precharge. It does not shorten a burst that has auto precharge.
- R12: illegal_o is high for exactly the one clock after a rejected command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples command |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| dsf | input | 1 | Special-function select for graphics variants |
| addr | input | AW (11) | Address bus: bank, all-bank, auto-precharge and mode bits |
| cmd_o | output | 4 | Classified command code |
| illegal_o | output | 1 | One-clock pulse for a rejected command |
| bank_active_o | output | 2 | Bank is open |
| bank_idle_o | output | 2 | Bank is precharged and ready |
| wpb_o | output | 2 | Write-per-bit mode of each open bank |
| burst_o | output | 2 | Bank has a burst in progress |
| mr_o | output | AW (11) | Mode register contents |
| smr_o | output | AW (11) | Special mode register contents |

## Verification
The case that needs the most care is a burst stop or a command to the other bank arriving while an auto-precharge burst is counting down. In that cycle the decoder must judge legality from the lock held by the other bank, while the bank's own countdown moves its state forward. The bench issues a read with auto precharge, a read to the other bank, a burst stop and a precharge of the locked bank, one on each of the following clocks. For each of these commands it compares illegal_o, burst_o and the bank flags with values worked out clock by clock from the burst length and TRP. It then probes the exact clock on which the lock releases, placing one read just before it and one just after.

// File: rtl/sgdram_pkg.sv
package sgdram_pkg;

  typedef enum logic [3:0] {
    C_NOP    = 4'd0,
    C_MRS    = 4'd1,
    C_SMRS   = 4'd2,
    C_ACT    = 4'd3,
    C_ACTM   = 4'd4,
    C_PRE    = 4'd5,
    C_PREALL = 4'd6,
    C_RD     = 4'd7,
    C_WR     = 4'd8,
    C_BWR    = 4'd9,
    C_BST    = 4'd10,
    C_REF    = 4'd11
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE   = 2'd0,
    B_ACTIVE = 2'd1,
    B_PRECH  = 2'd2
  } bank_e;

  // pin decode: {ras_n,cas_n,we_n} with chip select and graphics select
  function automatic cmd_e classify(input logic cs_n, input logic [2:0] rcw,
                                    input logic dsf, input logic all_bit);
    if (cs_n) return C_NOP;
    case (rcw)
      3'b000:  return dsf ? C_SMRS : C_MRS;
      3'b001:  return C_REF;
      3'b010:  return all_bit ? C_PREALL : C_PRE;
      3'b011:  return dsf ? C_ACTM : C_ACT;
      3'b100:  return dsf ? C_BWR : C_WR;
      3'b101:  return C_RD;
      3'b110:  return C_BST;
      default: return C_NOP;
    endcase
  endfunction

  // beats for a burst-length code
  function automatic logic [3:0] burst_beats(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sgdram_mode_regs.sv
module sgdram_mode_regs #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_mr,
  input  logic          load_smr,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] mr,
  output logic [AW-1:0] smr,
  output logic [3:0]    rd_len,
  output logic [3:0]    wr_len
);
  import sgdram_pkg::*;

  localparam int WBL_BIT = AW - 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mr  <= '0;
      smr <= '0;
    end else begin
      if (load_mr)  mr  <= addr;
      if (load_smr) smr <= addr;
    end
  end

  always_comb begin
    rd_len = burst_beats(mr[2:0]);
    wr_len = mr[WBL_BIT] ? 4'd1 : rd_len;
  end

  p_loads_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_mr && load_smr));

endmodule

// File: rtl/sgdram_bank.sv
module sgdram_bank #(
  parameter int TRP = 2,
  parameter int LW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_act,
  input  logic          act_dsf,
  input  logic          do_pre,
  input  logic          do_rdwr,
  input  logic          rdwr_ap,
  input  logic [LW-1:0] rdwr_len,
  input  logic          do_bst,
  output logic          is_idle,
  output logic          is_active,
  output logic          wpb,
  output logic          ap_pend,
  output logic          bursting
);
  import sgdram_pkg::*;

  localparam int TW = $clog2(TRP + 1);
  localparam logic [TW-1:0] TRP_V = TW'(TRP);

  bank_e         state_q;
  logic [TW-1:0] tcnt_q;
  logic [LW-1:0] rem_q;
  logic          wpb_q;
  logic          ap_q;

  // named internal events
  logic burst_last;
  logic prech_done;
  assign burst_last = (rem_q == LW'(1));
  assign prech_done = (state_q == B_PRECH) && (tcnt_q <= TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= B_IDLE;
      tcnt_q  <= '0;
      rem_q   <= '0;
      wpb_q   <= 1'b0;
      ap_q    <= 1'b0;
    end else if (do_act) begin
      state_q <= B_ACTIVE;
      wpb_q   <= act_dsf;
    end else if (do_pre) begin
      if (state_q == B_ACTIVE) begin
        state_q <= B_PRECH;
        tcnt_q  <= TRP_V;
        rem_q   <= '0;
        wpb_q   <= 1'b0;
      end
    end else if (do_rdwr) begin
      rem_q <= rdwr_len;
      ap_q  <= rdwr_ap;
    end else if (state_q == B_PRECH) begin
      if (prech_done) begin
        state_q <= B_IDLE;
        ap_q    <= 1'b0;
        tcnt_q  <= '0;
      end else begin
        tcnt_q <= tcnt_q - TW'(1);
      end
    end else if (do_bst && !ap_q) begin
      rem_q <= '0;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - LW'(1);
      if (burst_last && ap_q) begin
        state_q <= B_PRECH;
        tcnt_q  <= TRP_V;
        wpb_q   <= 1'b0;
      end
    end
  end

  assign is_idle   = (state_q == B_IDLE);
  assign is_active = (state_q == B_ACTIVE);
  assign wpb       = wpb_q;
  assign ap_pend   = ap_q;
  assign bursting  = (rem_q != '0);

  p_active_via_prech_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_active |=> !is_idle);
  p_wpb_from_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wpb) |-> $past(do_act && act_dsf));
  p_no_burst_when_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bursting |-> is_active);

endmodule

// File: rtl/sgdram_cmd_decoder.sv
module sgdram_cmd_decoder #(
  parameter int AW  = 11,
  parameter int TRP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          dsf,
  input  logic [AW-1:0] addr,
  output logic [3:0]    cmd_o,
  output logic          illegal_o,
  output logic [1:0]    bank_active_o,
  output logic [1:0]    bank_idle_o,
  output logic [1:0]    wpb_o,
  output logic [1:0]    burst_o,
  output logic [AW-1:0] mr_o,
  output logic [AW-1:0] smr_o
);
  import sgdram_pkg::*;

  localparam int NB      = 2;
  localparam int LW      = 4;
  localparam int BANK_B  = AW - 1;
  localparam int ALL_B   = AW - 2;
  localparam int AP_B    = AW - 3;

  cmd_e       cls;
  logic       bsel;
  logic       legal;
  logic       lock;
  logic [LW-1:0] rd_len, wr_len;
  logic [NB-1:0] idle_w, act_w, wpb_w, ap_w, burst_w;
  logic [NB-1:0] do_act, do_pre, do_rdwr;
  logic       is_rdwr, is_wr;

  assign cls     = classify(cs_n, {ras_n, cas_n, we_n}, dsf, addr[ALL_B]);
  assign bsel    = addr[BANK_B];
  assign lock    = |ap_w;
  assign is_wr   = (cls == C_WR) || (cls == C_BWR);
  assign is_rdwr = is_wr || (cls == C_RD);

  always_comb begin
    case (cls)
      C_MRS, C_SMRS, C_REF: legal = &idle_w;
      C_ACT, C_ACTM:        legal = idle_w[bsel];
      C_PRE:                legal = !ap_w[bsel];
      C_PREALL:             legal = !lock;
      C_RD, C_WR, C_BWR:    legal = act_w[bsel] && !lock;
      default:              legal = 1'b1;
    endcase
  end

  sgdram_mode_regs #(.AW(AW)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_mr  (legal && cls == C_MRS),
    .load_smr (legal && cls == C_SMRS),
    .addr     (addr),
    .mr       (mr_o),
    .smr      (smr_o),
    .rd_len   (rd_len),
    .wr_len   (wr_len)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign do_act[b]  = legal && (cls == C_ACT || cls == C_ACTM) && (bsel == 1'(b));
    assign do_pre[b]  = legal && ((cls == C_PREALL) || (cls == C_PRE && bsel == 1'(b)));
    assign do_rdwr[b] = legal && is_rdwr && (bsel == 1'(b));

    sgdram_bank #(.TRP(TRP), .LW(LW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_act    (do_act[b]),
      .act_dsf   (dsf),
      .do_pre    (do_pre[b]),
      .do_rdwr   (do_rdwr[b]),
      .rdwr_ap   (addr[AP_B]),
      .rdwr_len  (is_wr ? wr_len : rd_len),
      .do_bst    (legal && cls == C_BST),
      .is_idle   (idle_w[b]),
      .is_active (act_w[b]),
      .wpb       (wpb_w[b]),
      .ap_pend   (ap_w[b]),
      .bursting  (burst_w[b])
    );
  end

  cmd_e cmd_q;
  logic illegal_q;
  logic bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= C_NOP;
      illegal_q <= 1'b0;
      bank_q    <= 1'b0;
    end else begin
      cmd_q     <= cls;
      illegal_q <= !legal;
      bank_q    <= bsel;
    end
  end

  assign cmd_o         = cmd_q;
  assign illegal_o     = illegal_q;
  assign bank_active_o = act_w;
  assign bank_idle_o   = idle_w;
  assign wpb_o         = wpb_w;
  assign burst_o       = burst_w;

  logic rdwr_ok_q;
  assign rdwr_ok_q = !illegal_q && (cmd_q == C_RD || cmd_q == C_WR || cmd_q == C_BWR);

  p_ref_both_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF && !illegal_q) |-> $past(&idle_w));
  p_rdwr_bank0_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdwr_ok_q && !bank_q) |-> $past(act_w[0]));
  p_rdwr_bank1_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdwr_ok_q && bank_q) |-> $past(act_w[1]));
  p_mr_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mr_o) |-> (cmd_q == C_MRS && !illegal_q));
  p_lock_blocks_rdwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && is_rdwr) |=> illegal_o);

endmodule

// File: tb/sgdram_cmd_decoder_tb.sv
module sgdram_cmd_decoder_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, dsf = 0;
  logic [10:0] addr = '0;
  logic [3:0]  cmd_o;
  logic        illegal_o;
  logic [1:0]  bank_active_o, bank_idle_o, wpb_o, burst_o;
  logic [10:0] mr_o, smr_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sgdram_cmd_decoder #(.AW(11), .TRP(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .addr(addr), .cmd_o(cmd_o), .illegal_o(illegal_o),
    .bank_active_o(bank_active_o), .bank_idle_o(bank_idle_o), .wpb_o(wpb_o),
    .burst_o(burst_o), .mr_o(mr_o), .smr_o(smr_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one command, return just after the edge that sampled it
  task automatic issue(input logic c, input logic [2:0] rcw, input logic d, input logic [10:0] a);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; dsf = d; addr = a;
    @(posedge clk); #1;
    cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; dsf = 0; addr = '0;
  endtask

  task automatic nop();
    issue(1'b0, 3'b111, 1'b0, 11'h000);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  function automatic logic [3:0] exp_code(input logic c, input logic [2:0] rcw,
                                          input logic d, input logic a9);
    logic [3:0] r;
    if (c) return 4'd0;
    r = (rcw == 3'b000) ? (d ? 4'd2 : 4'd1) :
        (rcw == 3'b001) ? 4'd11 :
        (rcw == 3'b010) ? (a9 ? 4'd6 : 4'd5) :
        (rcw == 3'b011) ? (d ? 4'd4 : 4'd3) :
        (rcw == 3'b100) ? (d ? 4'd9 : 4'd8) :
        (rcw == 3'b101) ? 4'd7 :
        (rcw == 3'b110) ? 4'd10 : 4'd0;
    return r;
  endfunction

  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011,
                         WR  = 3'b100, RD  = 3'b101, BST = 3'b110;

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R12 reset illegal", illegal_o, 0);
    chk("R2 reset idle", bank_idle_o, 2'b11);
    chk("R8 reset mr", mr_o, 0);
    // R1 classification sweep over pins, dsf and the all-bank bit
    for (int i = 0; i < 64; i++) begin
      issue(i[3], i[2:0], i[4], {1'b0, i[5], 9'h000});
      chk("R1 decode", cmd_o, exp_code(i[3], i[2:0], i[4], i[5]));
    end
    do_reset();
    issue(0, MRS, 0, 11'h002);
    chk("R8 mr load", mr_o, 11'h002); chk("R5 mrs legal idle", illegal_o, 0);
    issue(0, MRS, 1, 11'h155);
    chk("R8 smr load", smr_o, 11'h155); chk("R8 mr kept", mr_o, 11'h002);
    chk("R1 smrs code", cmd_o, 2);
    issue(0, RD, 0, 11'h000);
    chk("R4 rd closed illegal", illegal_o, 1); chk("R4 state kept", bank_idle_o, 2'b11);
    issue(0, ACT, 1, 11'h000);
    chk("R12 pulse one clock", illegal_o, 0);
    chk("R6 masked act code", cmd_o, 4); chk("R2 bank0 open", bank_active_o, 2'b01);
    chk("R6 wpb set", wpb_o, 2'b01);
    issue(0, ACT, 0, 11'h000);
    chk("R2 act open bank illegal", illegal_o, 1); chk("R6 wpb kept", wpb_o, 2'b01);
    issue(0, REF, 0, 11'h000);
    chk("R5 ref illegal", illegal_o, 1);
    issue(0, MRS, 0, 11'h003);
    chk("R5 mrs illegal", illegal_o, 1); chk("R8 rejected load", mr_o, 11'h002);
    issue(0, ACT, 0, 11'h400);
    chk("R2 bank1 open", bank_active_o, 2'b11); chk("R6 wpb per bank", wpb_o, 2'b01);
    issue(0, WR, 1, 11'h400);
    chk("R7 block write code", cmd_o, 9); chk("R7 legal", illegal_o, 0);
    chk("R10 burst on", burst_o, 2'b10);
    nop(); chk("R10 burst mid", burst_o, 2'b10);
    issue(0, BST, 0, 11'h000);
    chk("R11 bst legal", illegal_o, 0); chk("R11 burst ended", burst_o, 2'b00);
    // auto-precharge read on bank 0, BL=4, TRP=2
    issue(0, RD, 0, 11'h100);
    chk("R9 ap rd legal", illegal_o, 0); chk("R10 ap burst", burst_o, 2'b01);
    issue(0, RD, 0, 11'h400);
    chk("R9 other bank locked", illegal_o, 1);
    issue(0, BST, 0, 11'h000);
    chk("R11 bst legal in ap", illegal_o, 0); chk("R11 ap burst continues", burst_o, 2'b01);
    issue(0, PRE, 0, 11'h000);
    chk("R9 pre locked bank illegal", illegal_o, 1); chk("R9 still active", bank_active_o, 2'b11);
    nop();
    chk("R9 auto prech", {bank_idle_o[0], bank_active_o[0]}, 2'b00);
    chk("R6 wpb cleared", wpb_o, 2'b00); chk("R10 burst done", burst_o, 2'b00);
    nop(); chk("R3 still prech", bank_idle_o, 2'b00);
    issue(0, RD, 0, 11'h400);
    chk("R9 lock to last clock", illegal_o, 1); chk("R9 bank0 idle", bank_idle_o, 2'b01);
    issue(0, RD, 0, 11'h400);
    chk("R9 lock released", illegal_o, 0);
    nop(); nop(); nop(); nop();
    issue(0, PRE, 0, 11'h200);
    chk("R3 preall code", cmd_o, 6); chk("R3 bank1 prech", bank_idle_o, 2'b01);
    chk("R3 neither active", bank_active_o, 2'b00);
    issue(0, ACT, 0, 11'h400);
    chk("R3 early act illegal", illegal_o, 1);
    nop(); chk("R3 idle after trp", bank_idle_o, 2'b11);
    issue(0, ACT, 0, 11'h400);
    chk("R3 act after trp", illegal_o, 0); chk("R3 bank1 open", bank_active_o, 2'b10);
    issue(0, ACT, 0, 11'h000);
    issue(0, PRE, 0, 11'h400);
    chk("R2 single pre bank1", bank_active_o, 2'b01);
    issue(0, PRE, 0, 11'h000);
    nop(); nop();
    issue(0, REF, 0, 11'h000);
    chk("R5 ref legal idle", illegal_o, 0); chk("R1 ref code", cmd_o, 11);
    // write burst length bit, BL code 2
    issue(0, MRS, 0, 11'h202);
    chk("R8 mr wbl", mr_o, 11'h202);
    issue(0, ACT, 0, 11'h000);
    issue(0, WR, 0, 11'h000);
    chk("R10 wbl write beat", burst_o, 2'b01);
    nop(); chk("R10 wbl single", burst_o, 2'b00);
    issue(0, RD, 0, 11'h000);
    nop(); nop(); nop();
    chk("R10 read 4th beat", burst_o, 2'b01);
    nop(); chk("R10 read over", burst_o, 2'b00);
    // BL code 6 gives 8 beats
    issue(0, PRE, 0, 11'h200); nop(); nop();
    issue(0, MRS, 0, 11'h006);
    issue(0, ACT, 0, 11'h400);
    issue(0, RD, 0, 11'h400);
    for (int k = 0; k < 7; k++) nop();
    chk("R10 8th beat", burst_o, 2'b10);
    nop(); chk("R10 8 beats over", burst_o, 2'b00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule